// File: doc/BRIEF.md
# Speculative Load Alias Check Table

This block tracks loads that a static scheduler has moved above earlier stores whose addresses were not known at compile time. When such a load issues early, it registers its destination register tag and its address in a small associative table. Every store that later executes searches all entries in parallel by address. Any entry whose 8-byte granule matches the store is marked stale, because the early load may have read data the store has since overwritten.

At the place where the load originally stood, a check operation looks the destination tag up in the table. The one-bit answer comes back on the next cycle. A pass means the speculatively loaded value can be used as is. A fail means the pipeline must branch to repair code. A tag that was never recorded, or whose entry was evicted or cleared, fails in the same way as one that a store hit. Optionally, a passing check also retires its entry.

Top module: `spec_alias_table`

## Requirements
- R1: While reset is high, and on the first cycle after it, rsp_valid is 0. After reset every entry is empty, so a check of any tag fails.
- R2: After an insert of a tag, with no store to the same granule in between, a check of that tag returns rsp_valid=1 and rsp_pass=1.
- R3: A store whose address matches a valid entry in bits [ADDR_W-1:3] invalidates that entry, even when bits [2:0] differ. A later check of that tag returns rsp_pass=0.
- R4: A store to a different granule leaves the entries unchanged.
- R5: A check of a tag that has no valid entry returns rsp_valid=1 and rsp_pass=0.
- R6: When a store and an insert fall in the same cycle with the same address, the store is applied first. The new entry stays valid.
- R7: An insert whose tag already has a valid entry overwrites that entry's address. The old address no longer protects the tag, and no second entry is created for it.
- R8: An insert with a new tag takes the lowest-numbered empty entry. If no entry is empty, it replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one only on such a replacement.
- R9: When chk_clear=1 and the check passes, the matching entry is emptied, so the next check of that tag fails. With chk_clear=0, or when the check fails, nothing changes.
- R10: rsp_valid is 1 exactly one cycle after a cycle with chk_valid=1 and 0 otherwise. rsp_pass is 0 whenever rsp_valid is 0.
- R11: A check sees the table as it stood before any store, insert or clear in the same cycle. Those updates become visible to checks from the next cycle on.
- R12: One store invalidates every valid entry in its granule at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Advanced load insert strobe |
| ld_tag | input | TAG_W | Destination register tag of the advanced load |
| ld_addr | input | ADDR_W | Byte address of the advanced load |
| st_valid | input | 1 | Store snoop strobe |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request strobe |
| chk_tag | input | TAG_W | Tag to look up |
| chk_clear | input | 1 | Empty the entry when the check passes |
| rsp_valid | output | 1 | Check response strobe, one cycle after the request |
| rsp_pass | output | 1 | 1 = speculation still valid, 0 = branch to repair code |

## Verification
A check's response is registered once, so it appears one clock edge after the request. Inserts, stores and clears change the table at the same edge. Their effect is first seen by a check issued in the following cycle, and its answer arrives one edge later still. The bench drives each vector half a cycle before an edge and compares rsp_valid and rsp_pass at the next falling edge against the values listed with that vector. This means every vector carries the answer to its own check. A cycle without a check expects rsp_valid=0.

// File: rtl/sat_pkg.sv
package sat_pkg;

  // Registered check answer.
  typedef struct packed {
    logic vld;
    logic pass;
  } sat_rsp_t;

  localparam sat_rsp_t SAT_RSP_IDLE = '{vld: 1'b0, pass: 1'b0};

endpackage

// File: rtl/sat_cam.sv
module sat_cam #(
  parameter int ENTRIES  = 16,
  parameter int TAG_W    = 7,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3,
  parameter int IDX_W    = $clog2(ENTRIES),
  localparam int GRAN_W  = ADDR_W - GRAN_LSB
) (
  input  logic               clk,
  input  logic               rst,
  // lookup keys
  input  logic [TAG_W-1:0]   ld_tag,
  input  logic [TAG_W-1:0]   chk_tag,
  input  logic [GRAN_W-1:0]  st_gran,
  // update
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [GRAN_W-1:0]  wr_gran,
  input  logic [ENTRIES-1:0] kill,
  // per-entry results
  output logic [ENTRIES-1:0] ent_valid,
  output logic [ENTRIES-1:0] ld_hit,
  output logic [ENTRIES-1:0] chk_hit,
  output logic [ENTRIES-1:0] st_hit
);

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [GRAN_W-1:0] gran_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    // Valid bit: reset, then insert beats kill (insert applied last).
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[e] <= 1'b0;
      end else if (sel) begin
        ent_valid[e] <= 1'b1;
      end else if (kill[e]) begin
        ent_valid[e] <= 1'b0;
      end
    end

    // Payload: no reset needed, qualified by the valid bit.
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e]  <= wr_tag;
        gran_q[e] <= wr_gran;
      end
    end

    assign ld_hit[e]  = ent_valid[e] && (tag_q[e]  == ld_tag);
    assign chk_hit[e] = ent_valid[e] && (tag_q[e]  == chk_tag);
    assign st_hit[e]  = ent_valid[e] && (gran_q[e] == st_gran);
  end

endmodule

// File: rtl/sat_alloc.sv
module sat_alloc #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  input  logic [ENTRIES-1:0] ld_hit,
  input  logic [ENTRIES-1:0] ent_valid,
  output logic [IDX_W-1:0]   wr_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_hit;
  logic             any_free;
  logic             replace;

  // Lowest-numbered set bit wins in both encoders.
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ld_hit[i])     hit_idx  = IDX_W'(i);
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |ld_hit;
  assign any_free = ~&ent_valid;
  assign replace  = ld_valid && !any_hit && !any_free;

  always_comb begin
    if (any_hit)       wr_idx = hit_idx;
    else if (any_free) wr_idx = free_idx;
    else               wr_idx = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (replace) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/sat_resp.sv
module sat_resp
  import sat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chk_valid,
  input  logic [ENTRIES-1:0] chk_hit,
  output logic               rsp_valid,
  output logic               rsp_pass
);

  sat_rsp_t rsp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= SAT_RSP_IDLE;
    end else begin
      rsp_q.vld  <= chk_valid;
      rsp_q.pass <= chk_valid && (|chk_hit);
    end
  end

  assign rsp_valid = rsp_q.vld;
  assign rsp_pass  = rsp_q.pass;

endmodule

// File: rtl/spec_alias_table.sv
module spec_alias_table #(
  parameter int ENTRIES  = 16,
  parameter int TAG_W    = 7,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int GRAN_W  = ADDR_W - GRAN_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_clear,
  output logic              rsp_valid,
  output logic              rsp_pass
);

  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ld_hit;
  logic [ENTRIES-1:0] chk_hit;
  logic [ENTRIES-1:0] st_hit;
  logic [ENTRIES-1:0] kill;
  logic [IDX_W-1:0]   wr_idx;
  logic               unused_low_bits;

  // Byte offsets inside a granule take no part in matching.
  assign unused_low_bits = ^{ld_addr[GRAN_LSB-1:0], st_addr[GRAN_LSB-1:0]};

  // Store snoop and passing clear-on-check both empty entries.
  assign kill = ({ENTRIES{st_valid}} & st_hit)
              | ({ENTRIES{chk_valid && chk_clear}} & chk_hit);

  sat_cam #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .ADDR_W  (ADDR_W),
    .GRAN_LSB(GRAN_LSB),
    .IDX_W   (IDX_W)
  ) cam_i (
    .clk      (clk),
    .rst      (rst),
    .ld_tag   (ld_tag),
    .chk_tag  (chk_tag),
    .st_gran  (st_addr[ADDR_W-1:GRAN_LSB]),
    .wr_en    (ld_valid),
    .wr_idx   (wr_idx),
    .wr_tag   (ld_tag),
    .wr_gran  (ld_addr[ADDR_W-1:GRAN_LSB]),
    .kill     (kill),
    .ent_valid(ent_valid),
    .ld_hit   (ld_hit),
    .chk_hit  (chk_hit),
    .st_hit   (st_hit)
  );

  sat_alloc #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) alloc_i (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_hit   (ld_hit),
    .ent_valid(ent_valid),
    .wr_idx   (wr_idx)
  );

  sat_resp #(
    .ENTRIES(ENTRIES)
  ) resp_i (
    .clk      (clk),
    .rst      (rst),
    .chk_valid(chk_valid),
    .chk_hit  (chk_hit),
    .rsp_valid(rsp_valid),
    .rsp_pass (rsp_pass)
  );

endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               ld_valid,
  input logic               st_valid,
  input logic               chk_valid,
  input logic               rsp_valid,
  input logic               rsp_pass,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] ld_hit,
  input logic [ENTRIES-1:0] chk_hit,
  input logic [ENTRIES-1:0] st_hit
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1: table empty and no response on the first cycle out of reset
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (ent_valid == '0 && !rsp_valid));

  // R10: response strobe follows the request by exactly one cycle
  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (rst)
    armed |-> (rsp_valid == $past(chk_valid)));

  // R10: no pass without a response
  assert_pass_qualified_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_pass);

  // R3 / R12: with no insert, every entry a store hits is empty afterwards
  assert_store_kills_R3: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !ld_valid) |=> ((ent_valid & $past(st_hit)) == '0));

  // R6: an insert always leaves at least one valid entry
  assert_insert_lands_R6: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (ent_valid != '0));

  // R7: a tag never owns more than one valid entry
  assert_unique_ld_tag_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_hit));
  assert_unique_chk_tag_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_hit));

endmodule

bind spec_alias_table sat_checker #(.ENTRIES(ENTRIES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ld_valid (ld_valid),
  .st_valid (st_valid),
  .chk_valid(chk_valid),
  .rsp_valid(rsp_valid),
  .rsp_pass (rsp_pass),
  .ent_valid(ent_valid),
  .ld_hit   (ld_hit),
  .chk_hit  (chk_hit),
  .st_hit   (st_hit)
);

// File: tb/spec_alias_table_tb.sv
module spec_alias_table_tb_top;

  localparam int TAG_W  = 7;
  localparam int ADDR_W = 32;
  localparam int VW     = 88;
  localparam int NVEC   = 28;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_valid = 1'b0;
  logic [TAG_W-1:0]  ld_tag = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic              st_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic              chk_valid = 1'b0;
  logic [TAG_W-1:0]  chk_tag = '0;
  logic              chk_clear = 1'b0;
  logic              rsp_valid;
  logic              rsp_pass;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  spec_alias_table dut_i (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
    .rsp_valid(rsp_valid), .rsp_pass(rsp_pass)
  );

  // Vector: ld_v, ld_tag, ld_addr, st_v, st_addr, chk_v, chk_tag, chk_clr,
  //         expected rsp_valid, expected rsp_pass, requirement number
  function automatic logic [VW-1:0] mk(
    input logic lv, input logic [6:0] lt, input logic [31:0] la,
    input logic sv, input logic [31:0] sa,
    input logic cv, input logic [6:0] ct, input logic cc,
    input logic ev, input logic ep, input logic [3:0] rq);
    return {lv, lt, la, sv, sa, cv, ct, cc, ev, ep, rq};
  endfunction

  localparam logic [VW-1:0] VEC [NVEC] = '{
    mk(0,0,0,        0,0,          1,5,0, 1,0, 5),  // R5 absent tag fails
    mk(1,5,32'h1000, 0,0,          0,0,0, 0,0,10),  // R10 no check, no rsp
    mk(0,0,0,        0,0,          1,5,0, 1,1, 2),  // R2 inserted tag passes
    mk(0,0,0,        1,32'h2000,   0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,5,0, 1,1, 4),  // R4 other granule
    mk(0,0,0,        1,32'h1007,   0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,5,0, 1,0, 3),  // R3 same granule kills
    mk(1,6,32'h3000, 1,32'h3000,   0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,6,0, 1,1, 6),  // R6 insert after store
    mk(1,6,32'h4000, 0,0,          0,0,0, 0,0,10),
    mk(0,0,0,        1,32'h4000,   0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,6,0, 1,0, 7),  // R7 old addr gone
    mk(1,6,32'h4000, 0,0,          0,0,0, 0,0,10),
    mk(0,0,0,        1,32'h3000,   0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,6,0, 1,1, 7),  // R7 old addr no effect
    mk(0,0,0,        1,32'h4004,   1,6,0, 1,1,11),  // R11 pre-store view
    mk(0,0,0,        0,0,          1,6,0, 1,0,11),  // R11 store seen next
    mk(1,7,32'h5000, 0,0,          0,0,0, 0,0,10),
    mk(1,8,32'h5000, 0,0,          0,0,0, 0,0,10),
    mk(0,0,0,        1,32'h5000,   0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,7,0, 1,0,12),  // R12 both killed
    mk(0,0,0,        0,0,          1,8,0, 1,0,12),
    mk(1,9,32'h6000, 0,0,          0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,9,1, 1,1, 9),  // R9 clear on pass
    mk(0,0,0,        0,0,          1,9,0, 1,0, 9),  // R9 now absent
    mk(1,10,32'h7000,0,0,          0,0,0, 0,0,10),
    mk(0,0,0,        0,0,          1,10,0,1,1, 9),  // R9 no clear
    mk(0,0,0,        0,0,          1,10,0,1,1, 9)
  };

  task automatic check(input logic ev, input logic ep, input int rq,
                       input string what);
    checks++;
    if (rsp_valid !== ev || rsp_pass !== ep) begin
      errors++;
      $display("FAIL R%0d %s: got valid=%0b pass=%0b expected valid=%0b pass=%0b",
               rq, what, rsp_valid, rsp_pass, ev, ep);
    end
  endtask

  task automatic step(input logic lv, input logic [6:0] lt, input logic [31:0] la,
                      input logic sv, input logic [31:0] sa,
                      input logic cv, input logic [6:0] ct, input logic cc);
    ld_valid = lv; ld_tag = lt; ld_addr = la;
    st_valid = sv; st_addr = sa;
    chk_valid = cv; chk_tag = ct; chk_clear = cc;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: no response while in reset
    check(1'b0, 1'b0, 1, "in reset");
    rst = 1'b0;

    // Table walk: response for vector i is sampled one edge later.
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[87], v[86:80], v[79:48], v[47], v[46:15], v[14], v[13:7], v[6]);
      check(v[5], v[4], int'(v[3:0]), $sformatf("vector %0d", i));
    end
    idle();
    check(1'b0, 1'b0, 10, "idle after table");

    // R1: reset empties the table (tag 10 was valid before)
    rst = 1'b1;
    step(0, 0, 0, 0, 0, 1, 10, 0);
    check(1'b0, 1'b0, 1, "check during reset");
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 1, 10, 0);
    check(1'b1, 1'b0, 1, "tag gone after reset");

    // R8: fill lowest-first, then round-robin from entry 0
    for (int k = 0; k < 16; k++) begin
      step(1, 7'(k), 32'h10000 + 32'(k) * 32'h100, 0, 0, 0, 0, 0);
    end
    step(0, 0, 0, 0, 0, 1, 3, 0);
    check(1'b1, 1'b1, 8, "tag 3 present in full table");
    step(1, 16, 32'h20000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    check(1'b1, 1'b0, 8, "entry 0 replaced first");
    step(0, 0, 0, 0, 0, 1, 16, 0);
    check(1'b1, 1'b1, 8, "replacing tag present");
    step(1, 17, 32'h20100, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0);
    check(1'b1, 1'b0, 8, "entry 1 replaced second");
    step(0, 0, 0, 0, 0, 1, 2, 0);
    check(1'b1, 1'b1, 8, "entry 2 kept");
    // free a slot (tag 5), new tag must use it, not the pointer
    step(0, 0, 0, 1, 32'h10500, 0, 0, 0);
    step(1, 20, 32'h30000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2, 0);
    check(1'b1, 1'b1, 8, "free entry preferred over pointer");
    step(0, 0, 0, 0, 0, 1, 20, 0);
    check(1'b1, 1'b1, 8, "tag in freed slot");
    step(0, 0, 0, 0, 0, 1, 5, 0);
    check(1'b1, 1'b0, 3, "stored-over tag fails");
    idle();
    check(1'b0, 1'b0, 10, "final idle");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule